// File: doc/BRIEF.md
# Time-Gated Ingress Stream Admission

This block decides, for every incoming frame header, whether the frame may enter the switch at this moment. A small associative table classifies the frame into one of a few streams by the combination of destination MAC address, VLAN ID and priority code point. Each classified stream has an admission gate. The gate opens and closes according to one shared cyclic schedule that starts at a programmed base time, which is compared with a synchronised nanosecond time input.

The schedule is a merged list of intervals. Each interval has a nonzero length in nanoseconds and a per-stream open mask, so the gates of all streams advance on a single thread. Within that thread, two intervals never begin at the same instant. Software loads the intervals while the engine is idle, then arms it with a base time and the index of the last interval. A busy flag rises when the engine is armed and falls when it is stopped. A frame that matches no stream is admitted without any gate check. A matched frame is admitted only while its gate is open.

Top module: `stream_gate_admit`

## Requirements
- R1: After reset, busy is 0, res_valid is 0, and no stream table entry is valid.
- R2: A frame hits a table entry only when its destination MAC, VLAN ID and PCP all equal the entry's stored values and the entry's valid bit is 1. If any single field differs, the frame misses.
- R3: A frame that misses every entry gives res_hit=0 and res_admit=1, whatever the schedule state.
- R4: A frame that hits gives res_admit=0 while no schedule is armed, and also while a schedule is armed but the frame's time is below the base time.
- R5: From the base time B, interval i is in force for times t with B+S(i) <= t < B+S(i)+dur(i), where S(i) is the sum of the earlier durations. Bit s of that interval's mask set to 1 opens the gate of the stream held at table index s.
- R6: After the interval at index sc_last ends, the schedule wraps to interval 0. The cycle length is the sum of the durations of intervals 0..sc_last.
- R7: res_valid is a one-cycle pulse in the cycle after frm_valid is taken. The decision uses the time value now_ns had at the clock edge where the frame was taken.
- R8: busy rises in the cycle after sc_start is accepted in the idle state and falls in the cycle after sc_stop. An sc_start while busy is ignored and keeps the running base time. sc_stop has priority over sc_start.
- R9: An interval write (sc_we) while busy is ignored.
- R10: An interval write with sc_dur equal to 0 is ignored, and the previous content of that interval is kept.
- R11: The stream table can be written at any time. If several valid entries hit, the lowest index decides which gate is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_ns | input | TIME_W | Synchronised time in nanoseconds |
| st_we | input | 1 | Stream table write strobe |
| st_idx | input | SIDX_W | Stream table index |
| st_valid | input | 1 | Valid bit written to the entry |
| st_mac | input | 48 | Destination MAC key |
| st_vid | input | 12 | VLAN ID key |
| st_pcp | input | 3 | PCP key |
| sc_we | input | 1 | Schedule interval write strobe |
| sc_idx | input | EIDX_W | Interval index |
| sc_dur | input | DUR_W | Interval length in ns |
| sc_mask | input | NSTREAM | Per-stream open mask of the interval |
| sc_start | input | 1 | Arm the schedule |
| sc_base | input | TIME_W | Base time used on arming |
| sc_last | input | EIDX_W | Index of the last interval in the cycle |
| sc_stop | input | 1 | Disarm the schedule |
| busy | output | 1 | Schedule armed (pending or running) |
| frm_valid | input | 1 | Frame header present |
| frm_mac | input | 48 | Frame destination MAC |
| frm_vid | input | 12 | Frame VLAN ID |
| frm_pcp | input | 3 | Frame PCP |
| res_valid | output | 1 | Decision valid |
| res_hit | output | 1 | Frame matched a stream |
| res_admit | output | 1 | 1 = admit, 0 = drop |

## Verification
The hardest case to reach is the pair of interval boundaries around the wrap. There the engine must step from the last interval back to interval 0 in exactly the clock where the time crosses the accumulated end time. A fixed-phase test would only land on a few points of the cycle. To cover the boundaries, the bench probes two streams with a long train of frames. The frame spacing of 20 ns against a 200 ns cycle makes the sample points walk through every interval and across several wraps. Each decision is compared against a modular-arithmetic model of the schedule. Arming again and writing intervals during that train then show that neither disturbs the running phase.

// File: rtl/stream_gate_admit_pkg.sv
package stream_gate_admit_pkg;
  localparam int MAC_W = 48;
  localparam int VID_W = 12;
  localparam int PCP_W = 3;

  typedef struct packed {
    logic [MAC_W-1:0] mac;
    logic [VID_W-1:0] vid;
    logic [PCP_W-1:0] pcp;
  } flow_key_t;

  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_PEND = 2'd1,
    GS_RUN  = 2'd2
  } gate_state_e;
endpackage

// File: rtl/flow_classifier.sv
module flow_classifier
  import stream_gate_admit_pkg::*;
#(
  parameter int NSTREAM = 8,
  localparam int SIDX_W = $clog2(NSTREAM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SIDX_W-1:0] wr_idx,
  input  logic              wr_valid,
  input  flow_key_t         wr_key,
  input  flow_key_t         q_key,
  output logic              q_hit,
  output logic [SIDX_W-1:0] q_idx
);
  flow_key_t        key_q [NSTREAM];
  logic [NSTREAM-1:0] vld_q;
  logic [NSTREAM-1:0] hit_vec;

  genvar gi;
  generate
    for (gi = 0; gi < NSTREAM; gi++) begin : g_entry
      logic sel;
      assign sel = wr_en && (wr_idx == SIDX_W'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   vld_q[gi] <= 1'b0;
        else if (sel) vld_q[gi] <= wr_valid;
      end

      always_ff @(posedge clk) begin
        if (sel) key_q[gi] <= wr_key;
      end

      assign hit_vec[gi] = vld_q[gi] && (key_q[gi] == q_key);
    end
  endgenerate

  always_comb begin
    q_hit = |hit_vec;
    q_idx = '0;
    for (int i = NSTREAM - 1; i >= 0; i--) begin
      if (hit_vec[i]) q_idx = SIDX_W'(i);
    end
  end
endmodule

// File: rtl/gate_schedule.sv
module gate_schedule
  import stream_gate_admit_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NENTRY  = 16,
  parameter int TIME_W  = 48,
  parameter int DUR_W   = 32,
  localparam int EIDX_W = $clog2(NENTRY)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIME_W-1:0]  now_ns,
  input  logic               wr_en,
  input  logic [EIDX_W-1:0]  wr_idx,
  input  logic [DUR_W-1:0]   wr_dur,
  input  logic [NSTREAM-1:0] wr_mask,
  input  logic               arm,
  input  logic [TIME_W-1:0]  arm_base,
  input  logic [EIDX_W-1:0]  arm_last,
  input  logic               disarm,
  output logic               busy,
  output logic [NSTREAM-1:0] open_mask
);
  logic [DUR_W-1:0]   dur_q  [NENTRY];
  logic [NSTREAM-1:0] mask_q [NENTRY];

  gate_state_e       st_q, st_d;
  logic [EIDX_W-1:0] ptr_q, ptr_d, last_q, last_d, nxt_ptr;
  logic [TIME_W-1:0] end_q, end_d, base_q, base_d;
  logic              go, step, wr_ok;

  assign wr_ok = wr_en && (st_q == GS_IDLE) && (wr_dur != '0);

  genvar gi;
  generate
    for (gi = 0; gi < NENTRY; gi++) begin : g_slot
      always_ff @(posedge clk) begin
        if (wr_ok && (wr_idx == EIDX_W'(gi))) begin
          dur_q[gi]  <= wr_dur;
          mask_q[gi] <= wr_mask;
        end
      end
    end
  endgenerate

  assign go      = (st_q == GS_PEND) && (now_ns >= base_q);
  assign step    = (st_q == GS_RUN)  && (now_ns >= end_q);
  assign nxt_ptr = (ptr_q == last_q) ? '0 : ptr_q + 1'b1;

  always_comb begin
    if (go)                  open_mask = mask_q[0];
    else if (st_q == GS_RUN) open_mask = step ? mask_q[nxt_ptr] : mask_q[ptr_q];
    else                     open_mask = '0;
  end

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    end_d  = end_q;
    base_d = base_q;
    last_d = last_q;
    if (disarm) begin
      st_d = GS_IDLE;
    end else begin
      unique case (st_q)
        GS_IDLE: if (arm) begin
          st_d   = GS_PEND;
          base_d = arm_base;
          last_d = arm_last;
        end
        GS_PEND: if (go) begin
          st_d  = GS_RUN;
          ptr_d = '0;
          end_d = base_q + TIME_W'(dur_q[0]);
        end
        GS_RUN: if (step) begin
          ptr_d = nxt_ptr;
          end_d = end_q + TIME_W'(dur_q[nxt_ptr]);
        end
        default: st_d = GS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= GS_IDLE;
      ptr_q  <= '0;
      end_q  <= '0;
      base_q <= '0;
      last_q <= '0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      end_q  <= end_d;
      base_q <= base_d;
      last_q <= last_d;
    end
  end

  assign busy = (st_q != GS_IDLE);
endmodule

// File: rtl/stream_gate_admit.sv
module stream_gate_admit
  import stream_gate_admit_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NENTRY  = 16,
  parameter int TIME_W  = 48,
  parameter int DUR_W   = 32,
  localparam int SIDX_W = $clog2(NSTREAM),
  localparam int EIDX_W = $clog2(NENTRY)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIME_W-1:0]  now_ns,
  input  logic               st_we,
  input  logic [SIDX_W-1:0]  st_idx,
  input  logic               st_valid,
  input  logic [47:0]        st_mac,
  input  logic [11:0]        st_vid,
  input  logic [2:0]         st_pcp,
  input  logic               sc_we,
  input  logic [EIDX_W-1:0]  sc_idx,
  input  logic [DUR_W-1:0]   sc_dur,
  input  logic [NSTREAM-1:0] sc_mask,
  input  logic               sc_start,
  input  logic [TIME_W-1:0]  sc_base,
  input  logic [EIDX_W-1:0]  sc_last,
  input  logic               sc_stop,
  output logic               busy,
  input  logic               frm_valid,
  input  logic [47:0]        frm_mac,
  input  logic [11:0]        frm_vid,
  input  logic [2:0]         frm_pcp,
  output logic               res_valid,
  output logic               res_hit,
  output logic               res_admit
);
  logic              rst_meta, rst_n_s;
  flow_key_t         wkey, qkey;
  logic              hit;
  logic [SIDX_W-1:0] hit_idx;
  logic [NSTREAM-1:0] open_mask;
  logic              admit_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  assign wkey = '{mac: st_mac,  vid: st_vid,  pcp: st_pcp};
  assign qkey = '{mac: frm_mac, vid: frm_vid, pcp: frm_pcp};

  flow_classifier #(.NSTREAM(NSTREAM)) cls_i (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(st_we), .wr_idx(st_idx), .wr_valid(st_valid), .wr_key(wkey),
    .q_key(qkey), .q_hit(hit), .q_idx(hit_idx)
  );

  gate_schedule #(.NSTREAM(NSTREAM), .NENTRY(NENTRY), .TIME_W(TIME_W), .DUR_W(DUR_W)) sch_i (
    .clk(clk), .rst_n(rst_n_s), .now_ns(now_ns),
    .wr_en(sc_we), .wr_idx(sc_idx), .wr_dur(sc_dur), .wr_mask(sc_mask),
    .arm(sc_start), .arm_base(sc_base), .arm_last(sc_last), .disarm(sc_stop),
    .busy(busy), .open_mask(open_mask)
  );

  assign admit_d = !hit || open_mask[hit_idx];

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_admit <= 1'b0;
    end else begin
      res_valid <= frm_valid;
      if (frm_valid) begin
        res_hit   <= hit;
        res_admit <= admit_d;
      end
    end
  end
endmodule

// File: rtl/stream_gate_admit_chk.sv
module stream_gate_admit_chk (
  input logic clk,
  input logic rst_n,
  input logic frm_valid,
  input logic res_valid,
  input logic res_hit,
  input logic res_admit,
  input logic sc_start,
  input logic sc_stop,
  input logic busy
);
  assert_result_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> res_valid);
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !res_valid);
  assert_miss_admits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> res_admit);
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_start && !sc_stop) |=> busy);
  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sc_stop |=> !busy);
  assert_idle_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit && !$past(busy)) |-> !res_admit);
endmodule

bind stream_gate_admit stream_gate_admit_chk chk_i (
  .clk(clk), .rst_n(rst_n_s), .frm_valid(frm_valid), .res_valid(res_valid),
  .res_hit(res_hit), .res_admit(res_admit), .sc_start(sc_start),
  .sc_stop(sc_stop), .busy(busy)
);

// File: tb/stream_gate_admit_tb_top.sv
module stream_gate_admit_tb_top;
  localparam int NSTREAM = 8;
  localparam int NENTRY  = 16;
  localparam int TIME_W  = 48;
  localparam int DUR_W   = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [TIME_W-1:0] now_ns;
  logic st_we, st_valid; logic [2:0] st_idx; logic [47:0] st_mac; logic [11:0] st_vid; logic [2:0] st_pcp;
  logic sc_we, sc_start, sc_stop; logic [3:0] sc_idx, sc_last; logic [DUR_W-1:0] sc_dur;
  logic [NSTREAM-1:0] sc_mask; logic [TIME_W-1:0] sc_base;
  logic busy, frm_valid, res_valid, res_hit, res_admit;
  logic [47:0] frm_mac; logic [11:0] frm_vid; logic [2:0] frm_pcp;

  int total = 0, bad = 0;

  longint m_dur [16];
  logic [NSTREAM-1:0] m_mask [16];
  int     m_last;
  longint m_base;
  bit     m_run;

  localparam logic [47:0] MAC_A = 48'h02_00_00_00_00_0A;
  localparam logic [47:0] MAC_B = 48'h02_00_00_00_00_0B;
  localparam logic [47:0] MAC_C = 48'h02_00_00_00_00_0C;

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) now_ns <= '0;
    else        now_ns <= now_ns + 48'd10;

  stream_gate_admit #(.NSTREAM(NSTREAM), .NENTRY(NENTRY), .TIME_W(TIME_W), .DUR_W(DUR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .now_ns(now_ns),
    .st_we(st_we), .st_idx(st_idx), .st_valid(st_valid), .st_mac(st_mac), .st_vid(st_vid), .st_pcp(st_pcp),
    .sc_we(sc_we), .sc_idx(sc_idx), .sc_dur(sc_dur), .sc_mask(sc_mask),
    .sc_start(sc_start), .sc_base(sc_base), .sc_last(sc_last), .sc_stop(sc_stop),
    .busy(busy), .frm_valid(frm_valid), .frm_mac(frm_mac), .frm_vid(frm_vid), .frm_pcp(frm_pcp),
    .res_valid(res_valid), .res_hit(res_hit), .res_admit(res_admit)
  );

  task automatic check(input string req, input longint act, input longint exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit model_open(input int s, input longint t);
    longint cyc, off;
    if (!m_run || t < m_base) return 1'b0;
    cyc = 0;
    for (int i = 0; i <= m_last; i++) cyc += m_dur[i];
    off = (t - m_base) % cyc;
    for (int i = 0; i <= m_last; i++) begin
      if (off < m_dur[i]) return m_mask[i][s];
      off -= m_dur[i];
    end
    return 1'b0;
  endfunction

  task automatic put_stream(input int idx, input bit v, input logic [47:0] mac, input logic [11:0] vid, input logic [2:0] pcp);
    @(negedge clk);
    st_we = 1; st_idx = 3'(idx); st_valid = v; st_mac = mac; st_vid = vid; st_pcp = pcp;
    @(negedge clk);
    st_we = 0;
  endtask

  task automatic put_entry(input int idx, input int dur, input logic [NSTREAM-1:0] mask);
    @(negedge clk);
    sc_we = 1; sc_idx = 4'(idx); sc_dur = DUR_W'(dur); sc_mask = mask;
    @(negedge clk);
    sc_we = 0;
  endtask

  task automatic arm(input longint delay, input int last);
    @(negedge clk);
    sc_start = 1; sc_base = now_ns + TIME_W'(delay); sc_last = 4'(last);
    @(negedge clk);
    sc_start = 0;
  endtask

  task automatic disarm();
    @(negedge clk);
    sc_stop = 1;
    @(negedge clk);
    sc_stop = 0;
  endtask

  // One frame; compares hit/admit with the model at the edge the frame is taken.
  task automatic probe(input string req, input logic [47:0] mac, input logic [11:0] vid, input logic [2:0] pcp,
                       input bit exp_hit, input int sidx);
    longint t;
    bit exp_admit;
    @(negedge clk);
    t = longint'(now_ns);
    frm_valid = 1; frm_mac = mac; frm_vid = vid; frm_pcp = pcp;
    @(negedge clk);
    frm_valid = 0;
    exp_admit = !exp_hit || model_open(sidx, t);
    check("R7", longint'(res_valid), 1, "res_valid");
    check(req, longint'(res_hit), longint'(exp_hit), "res_hit");
    check(req, longint'(res_admit), longint'(exp_admit), $sformatf("res_admit t=%0d", t));
  endtask

  task automatic t_reset();
    check("R1", longint'(busy), 0, "busy after reset");
    check("R1", longint'(res_valid), 0, "res_valid after reset");
    probe("R1", MAC_A, 12'd10, 3'd3, 1'b0, 0);
    @(negedge clk);
    check("R7", longint'(res_valid), 0, "res_valid pulse ends");
  endtask

  task automatic t_match();
    put_stream(0, 1, MAC_A, 12'd10, 3'd3);
    put_stream(1, 1, MAC_B, 12'd20, 3'd5);
    put_stream(2, 0, MAC_C, 12'd30, 3'd1);
    probe("R2", MAC_A, 12'd11, 3'd3, 1'b0, 0);
    probe("R2", MAC_A, 12'd10, 3'd2, 1'b0, 0);
    probe("R2", MAC_B, 12'd10, 3'd3, 1'b0, 0);
    probe("R11", MAC_C, 12'd30, 3'd1, 1'b0, 0);
    probe("R4", MAC_A, 12'd10, 3'd3, 1'b1, 0);
    probe("R3", 48'h0, 12'd0, 3'd0, 1'b0, 0);
  endtask

  task automatic t_schedule();
    put_entry(0, 100, 8'b0000_0001); m_dur[0] = 100; m_mask[0] = 8'b0000_0001;
    put_entry(1, 60,  8'b0000_0010); m_dur[1] = 60;  m_mask[1] = 8'b0000_0010;
    put_entry(2, 40,  8'b0000_0000); m_dur[2] = 40;  m_mask[2] = 8'b0000_0000;
    put_entry(1, 0,   8'b1111_1111); // R10: zero length ignored
    @(negedge clk);
    m_base = longint'(now_ns) + 300; m_last = 2; m_run = 1;
    sc_start = 1; sc_base = now_ns + 48'd300; sc_last = 4'd2;
    @(negedge clk);
    sc_start = 0;
    check("R8", longint'(busy), 1, "busy after arming");
    for (int i = 0; i < 60; i++) begin
      probe((i < 7) ? "R4" : "R5", MAC_A, 12'd10, 3'd3, 1'b1, 0);
      probe((i < 7) ? "R4" : "R6", MAC_B, 12'd20, 3'd5, 1'b1, 1);
    end
    arm(5000, 0);                       // R8: ignored while busy
    put_entry(0, 30, 8'b1111_1111);     // R9: ignored while busy
    for (int i = 0; i < 30; i++) begin
      probe("R9", MAC_A, 12'd10, 3'd3, 1'b1, 0);
      probe("R8", MAC_B, 12'd20, 3'd5, 1'b1, 1);
      probe("R10", MAC_B, 12'd20, 3'd5, 1'b1, 1);
    end
    probe("R3", MAC_C, 12'd99, 3'd7, 1'b0, 0);
    disarm(); m_run = 0;
    check("R8", longint'(busy), 0, "busy after stop");
    probe("R4", MAC_A, 12'd10, 3'd3, 1'b1, 0);
  endtask

  task automatic t_single();
    put_stream(3, 1, MAC_A, 12'd10, 3'd3); // duplicate of index 0
    put_stream(4, 1, MAC_C, 12'd40, 3'd0);
    @(negedge clk);
    m_base = longint'(now_ns) + 50; m_last = 0; m_run = 1;
    sc_start = 1; sc_base = now_ns + 48'd50; sc_last = 4'd0;
    @(negedge clk);
    sc_start = 0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      probe("R11", MAC_A, 12'd10, 3'd3, 1'b1, 0);
      probe("R6", MAC_C, 12'd40, 3'd0, 1'b1, 4);
    end
    disarm(); m_run = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0;
    st_we = 0; st_idx = '0; st_valid = 0; st_mac = '0; st_vid = '0; st_pcp = '0;
    sc_we = 0; sc_idx = '0; sc_dur = '0; sc_mask = '0; sc_start = 0; sc_base = '0; sc_last = '0; sc_stop = 0;
    frm_valid = 0; frm_mac = '0; frm_vid = '0; frm_pcp = '0;
    m_run = 0; m_base = 0; m_last = 0;
    for (int i = 0; i < 16; i++) begin m_dur[i] = 1; m_mask[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_match();
    t_schedule();
    t_single();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule